// File: doc/BRIEF.md
# I2C Bus Framing State Detector

This block sits on the raw data and clock lines of a two-wire serial slave and tells the bit engine behind it when a transaction is open. It has no free-running clock. The line transitions themselves clock its storage. A falling data edge loads the clock level into a start element, so that element sets only on a START. A rising data edge loads the clock level into a stop element, so that element sets only on a STOP. The two elements clear each other through their asynchronous resets. The stop element therefore gives a self-timed pulse and then both return to clear.

Three outputs come out of the block:
- A bus-active flag, which is high from a START up to the STOP that follows it.
- A restart strobe, which marks every START for the rest of the current clock-high phase. The bit engine uses it to reset its bit counter on a repeated START.
- A frame toggle, which flips once for every STOP that closes an open frame.

Clock activity and data changes are ignored while no START has been seen.

Top module: `i2c_frame_detect`

## Requirements
- R1: While `rst_n` is low, `active`, `restart` and `frame_tgl` are all 0, whatever the bus does.
- R2: With `active` low, a falling edge on `sda` while `scl` is 1 (a START) sets `active` to 1.
- R3: While `active` is low, toggling `scl`, changing `sda` while `scl` is 0, and a rising `sda` while `scl` is 1 leave `active` at 0 and `frame_tgl` unchanged.
- R4: While `active` is high, `sda` changes made while `scl` is 0 (data bits) keep `active` at 1.
- R5: While `active` is high, a rising `sda` while `scl` is 1 (a STOP) clears `active` and inverts `frame_tgl`.
- R6: A STOP followed by a START in the same `scl` high phase drops `active` and then raises it again, and inverts `frame_tgl` exactly once.
- R7: A START followed directly by a STOP with no `scl` edge between them (an empty frame) leaves `active` at 0 and inverts `frame_tgl`. A later START sets `active` again.
- R8: A START while `active` is already high (a repeated START) keeps `active` at 1, leaves `frame_tgl` unchanged and raises `restart`.
- R9: After any START, `restart` is 1 until `scl` next falls. It is 0 whenever `scl` is 0 and whenever `active` is 0.
- R10: `active` and `frame_tgl` change only while `scl` is 1. The stop element is clear again before the next rising edge of `scl`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sda | input | 1 | Serial data line level, as received |
| scl | input | 1 | Serial clock line level, as received |
| active | output | 1 | High between a START and the STOP that follows it |
| restart | output | 1 | High from a START until `scl` next falls |
| frame_tgl | output | 1 | Inverts once for each STOP that closes an open frame |

## Verification
A start element that fails to set or to hold shows as `active` staying low after a START, or dropping on a data bit within the same clock phase. A stop element that fails to clear is first visible at the next START: `active` stays low because the start element is still held in reset. The empty frame and the back-to-back STOP/START cases are therefore each followed by a fresh START. A restart strobe that outlives its phase shows as `restart` still high when `scl` is low. A frame toggle that misses or double-counts a STOP differs from the expected parity at the very next check.

// File: rtl/i2c_frame_pkg.sv
`timescale 1ns/1ps
package i2c_frame_pkg;
  // Line levels as seen on the bus
  localparam logic LINE_HIGH = 1'b1;
  localparam logic LINE_LOW  = 1'b0;
  // Value the elements take under reset
  localparam logic CELL_CLEAR = 1'b0;
endpackage

// File: rtl/frame_start_cell.sv
`timescale 1ns/1ps
// Start element: clocked by the falling data edge, it loads the clock level.
// Once set, it holds through data bits (falling data edges with the clock low).
module frame_start_cell
  import i2c_frame_pkg::*;
(
  input  logic sda_i,
  input  logic scl_i,
  input  logic clr_n_i,
  output logic open_o
);
  logic open_d;

  // next state: START sets, a data bit keeps the current state
  always_comb begin
    open_d = open_o;
    if (scl_i == LINE_HIGH) open_d = LINE_HIGH;
  end

  // R2 R4: register
  always_ff @(negedge sda_i or negedge clr_n_i) begin
    if (!clr_n_i) open_o <= CELL_CLEAR;
    else          open_o <= open_d;
  end
endmodule

// File: rtl/frame_stop_cell.sv
`timescale 1ns/1ps
// Stop element: clocked by the rising data edge, it loads the clock level.
// It is held clear while no frame is open. It also keeps the frame parity.
module frame_stop_cell
  import i2c_frame_pkg::*;
(
  input  logic sda_i,
  input  logic scl_i,
  input  logic rst_n_i,
  input  logic open_i,
  output logic close_o,
  output logic parity_o
);
  logic hold_n;
  logic parity_en;
  logic parity_d;

  assign hold_n    = rst_n_i & open_i;
  assign parity_en = (scl_i == LINE_HIGH) & open_i;
  assign parity_d  = parity_en ? ~parity_o : parity_o;

  // R5: self-timed close pulse, cleared once the start element drops
  always_ff @(posedge sda_i or negedge hold_n) begin
    if (!hold_n) close_o <= CELL_CLEAR;
    else         close_o <= scl_i;
  end

  // R5 R6 R7: one inversion per STOP that ends an open frame
  always_ff @(posedge sda_i or negedge rst_n_i) begin
    if (!rst_n_i) parity_o <= CELL_CLEAR;
    else          parity_o <= parity_d;
  end
endmodule

// File: rtl/restart_strobe_cell.sv
`timescale 1ns/1ps
// Marks a START for the rest of the current clock-high phase.
module restart_strobe_cell
  import i2c_frame_pkg::*;
(
  input  logic sda_i,
  input  logic scl_i,
  input  logic rst_n_i,
  output logic mark_o
);
  logic clr_n;

  // R9: held clear whenever the clock line is low
  assign clr_n = rst_n_i & (scl_i == LINE_HIGH);

  always_ff @(negedge sda_i or negedge clr_n) begin
    if (!clr_n) mark_o <= CELL_CLEAR;
    else        mark_o <= scl_i;
  end
endmodule

// File: rtl/i2c_frame_detect.sv
`timescale 1ns/1ps
// Framing detector: two edge-clocked elements that clear each other.
module i2c_frame_detect (
  input  logic rst_n,
  input  logic sda,
  input  logic scl,
  output logic active,
  output logic restart,
  output logic frame_tgl
);
  logic start_q;
  logic stop_q;
  logic start_clr_n;
  logic mark_q;

  // R1: reset clears both; a set stop element clears the start element
  assign start_clr_n = rst_n & ~stop_q;

  frame_start_cell u_start (
    .sda_i   (sda),
    .scl_i   (scl),
    .clr_n_i (start_clr_n),
    .open_o  (start_q)
  );

  frame_stop_cell u_stop (
    .sda_i    (sda),
    .scl_i    (scl),
    .rst_n_i  (rst_n),
    .open_i   (start_q),
    .close_o  (stop_q),
    .parity_o (frame_tgl)
  );

  restart_strobe_cell u_mark (
    .sda_i   (sda),
    .scl_i   (scl),
    .rst_n_i (rst_n),
    .mark_o  (mark_q)
  );

  assign active  = start_q;
  // R8 R9: a START only counts while a frame is open
  assign restart = mark_q & start_q;
endmodule

// File: rtl/i2c_frame_detect_chk.sv
`timescale 1ns/1ps
module i2c_frame_detect_chk (
  input logic rst_n,
  input logic scl,
  input logic active,
  input logic restart,
  input logic frame_tgl,
  input logic stop_q
);
  logic act_at_fall;
  logic tgl_at_fall;

  always_ff @(negedge scl or negedge rst_n) begin
    if (!rst_n) begin
      act_at_fall <= 1'b0;
      tgl_at_fall <= 1'b0;
    end else begin
      act_at_fall <= active;
      tgl_at_fall <= frame_tgl;
    end
  end

  // R9
  restart_low_on_rise_chk: assert property (@(posedge scl) disable iff (rst_n !== 1'b1)
    !restart);

  // R10
  active_still_when_low_chk: assert property (@(posedge scl) disable iff (rst_n !== 1'b1)
    active == act_at_fall);

  // R10
  tgl_still_when_low_chk: assert property (@(posedge scl) disable iff (rst_n !== 1'b1)
    frame_tgl == tgl_at_fall);

  // R10
  stop_cleared_chk: assert property (@(posedge scl) disable iff (rst_n !== 1'b1)
    !stop_q);
endmodule

bind i2c_frame_detect i2c_frame_detect_chk u_chk (
  .rst_n     (rst_n),
  .scl       (scl),
  .active    (active),
  .restart   (restart),
  .frame_tgl (frame_tgl),
  .stop_q    (stop_q)
);

// File: tb/i2c_frame_detect_test.sv
`timescale 1ns/1ps
module i2c_frame_detect_test;
  typedef struct {
    logic  act;
    logic  rst;
    logic  tgl;
    string tag;
  } exp_item_t;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic sda   = 1'b1;
  logic scl   = 1'b1;
  logic active, restart, frame_tgl;

  exp_item_t sb_q[$];
  int total = 0;
  int bad = 0;
  int issued = 0;
  int done = 0;
  int cycles = 0;
  logic exp_tgl = 1'b0;

  i2c_frame_detect uut (
    .rst_n(rst_n), .sda(sda), .scl(scl),
    .active(active), .restart(restart), .frame_tgl(frame_tgl)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // monitor: pops expectations and compares away from the clock edge
  initial begin
    forever begin
      wait (sb_q.size() != 0);
      @(negedge clk);
      begin
        exp_item_t it;
        it = sb_q.pop_front();
        total++;
        if (active !== it.act || restart !== it.rst || frame_tgl !== it.tgl) begin
          bad++;
          $display("FAIL %s: actual act=%b rst=%b tgl=%b expected act=%b rst=%b tgl=%b",
                   it.tag, active, restart, frame_tgl, it.act, it.rst, it.tgl);
        end
      end
      done++;
    end
  end

  task automatic expect_out(input logic a, input logic r, input logic t, input string tag);
    exp_item_t it;
    it.act = a; it.rst = r; it.tgl = t; it.tag = tag;
    issued++;
    sb_q.push_back(it);
    wait (done == issued);
  endtask

  task automatic drive_scl(input logic v);
    scl = v; #20;
  endtask

  task automatic drive_sda(input logic v);
    sda = v; #20;
  endtask

  // from idle (both high): START, then clock low
  task automatic open_frame(input string tag);
    drive_sda(1'b0);
    expect_out(1'b1, 1'b1, exp_tgl, tag);
    drive_scl(1'b0);
    expect_out(1'b1, 1'b0, exp_tgl, "R9");
  endtask

  task automatic send_bits(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      drive_sda(b[i]);
      drive_scl(1'b1);
      expect_out(1'b1, 1'b0, exp_tgl, "R4");
      drive_scl(1'b0);
    end
  endtask

  // from clock low: STOP
  task automatic close_frame(input string tag);
    drive_sda(1'b0);
    drive_scl(1'b1);
    drive_sda(1'b1);
    exp_tgl = ~exp_tgl;
    expect_out(1'b0, 1'b0, exp_tgl, tag);
  endtask

  initial begin
    #30;
    expect_out(1'b0, 1'b0, 1'b0, "R1");
    rst_n = 1'b1; #20;

    // R3: bus chatter with no START
    for (int k = 0; k < 4; k++) begin
      drive_scl(1'b0);
      drive_sda(k[0]);
      drive_scl(1'b1);
      expect_out(1'b0, 1'b0, exp_tgl, "R3");
    end
    drive_scl(1'b0); drive_sda(1'b0); drive_scl(1'b1);
    drive_sda(1'b1);
    expect_out(1'b0, 1'b0, exp_tgl, "R3");

    // normal frame
    open_frame("R2");
    send_bits(8'hA5);
    close_frame("R5");

    // back-to-back STOP and START in one clock-high phase
    open_frame("R2");
    send_bits(8'h3C);
    drive_sda(1'b0);
    drive_scl(1'b1);
    drive_sda(1'b1);
    exp_tgl = ~exp_tgl;
    expect_out(1'b0, 1'b0, exp_tgl, "R6");
    drive_sda(1'b0);
    expect_out(1'b1, 1'b1, exp_tgl, "R6");
    drive_scl(1'b0);
    expect_out(1'b1, 1'b0, exp_tgl, "R10");
    send_bits(8'h81);
    close_frame("R5");

    // empty frame, then chatter, then a fresh START
    drive_sda(1'b0);
    expect_out(1'b1, 1'b1, exp_tgl, "R7");
    drive_sda(1'b1);
    exp_tgl = ~exp_tgl;
    expect_out(1'b0, 1'b0, exp_tgl, "R7");
    drive_scl(1'b0); drive_scl(1'b1);
    expect_out(1'b0, 1'b0, exp_tgl, "R7");
    open_frame("R7");

    // repeated START
    send_bits(8'h5A);
    drive_sda(1'b1);
    drive_scl(1'b1);
    drive_sda(1'b0);
    expect_out(1'b1, 1'b1, exp_tgl, "R8");
    drive_scl(1'b0);
    expect_out(1'b1, 1'b0, exp_tgl, "R9");
    send_bits(8'h0F);
    close_frame("R5");

    // reset in the middle of a frame
    open_frame("R2");
    rst_n = 1'b0; #20;
    exp_tgl = 1'b0;
    expect_out(1'b0, 1'b0, 1'b0, "R1");
    rst_n = 1'b1; #20;
    drive_scl(1'b1);
    drive_sda(1'b1);
    expect_out(1'b0, 1'b0, 1'b0, "R3");
    open_frame("R2");
    close_frame("R5");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule